// File: doc/BRIEF.md
# Timeslot to Channel Assigner

This block sits between the framed serial links and the per-channel frame processors. Each physical link delivers one bit per enable strobe, and a frame-start strobe marks the first bit of each frame. The block keeps, for every link, a bit counter and a timeslot counter. It looks up the current timeslot in a per-link mapping table and emits the bit one cycle later. The output bit carries a valid flag and the number of the logical channel that owns it.

Each link runs in one of four modes. In unchannelized mode every bit goes to a single channel. In T1 mode each frame is one framing bit followed by 24 timeslots. In E1 mode each frame is 32 timeslots and timeslot 0 is reserved. In idle mode the link is silent. Any set of timeslots, adjacent or not, may feed one channel. Links in different modes run side by side.

Software-style writes go into a shadow copy of the table and the link settings. Each link copies its shadow into its active copy on its own frame-start bit, so a frame is never split across two mappings.

Top module: `tsa_top`

## Requirements
- R1: During reset and after it, `out_vld` is 0 on every link until a mode is written and a frame-start bit arrives; reset puts every link in idle mode and disables every table entry.
- R2: In unchannelized mode (code 2'b00), every bit strobed by `rx_en` appears on `out_bit` one cycle later with `out_vld`=1 and `out_chan` equal to the link channel.
- R3: In T1 mode (code 2'b01), the bit carrying the frame-start strobe is the framing bit and is never valid. The next 192 bits form timeslots 1 to 24 of 8 bits each, and after timeslot 24 the next bit is again a framing bit.
- R4: In E1 mode (code 2'b10), the frame-start bit is the first bit of timeslot 0. Timeslot 0 is never forwarded, even if its entry is enabled. Timeslots 1 to 31 follow at 8 bits each and wrap to timeslot 0.
- R5: A table entry holds an enable bit and a 7-bit channel. Bits of a channelized timeslot whose entry is disabled give `out_vld`=0; bits of an enabled one carry the entry's channel.
- R6: Several timeslots, adjacent or not, may carry the same channel number and all forward to it.
- R7: Table and mode writes for a link take effect starting with the next frame-start bit of that link, including that bit itself; until then the previous mapping stays in use.
- R8: Links count and map independently, and all modes may be active at once on different links.
- R9: In idle mode (code 2'b11), no bit of the link is forwarded.
- R10: A cycle with `rx_en` low on a link gives `out_vld`=0 on that link one cycle later and does not advance that link's counters; `rx_fp` without `rx_en` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_en | input | NUM_LINKS | Per-link bit strobe |
| rx_bit | input | NUM_LINKS | Per-link serial data bit |
| rx_fp | input | NUM_LINKS | Per-link frame-start, valid with `rx_en` |
| map_we | input | 1 | Table write strobe |
| map_link | input | LINK_W | Link of the table write |
| map_slot | input | 5 | Timeslot of the table write |
| map_en | input | 1 | Enable bit written |
| map_chan | input | 7 | Channel written |
| mode_we | input | 1 | Link setting write strobe |
| mode_link | input | LINK_W | Link of the setting write |
| mode_sel | input | 2 | Mode: 00 unchannelized, 01 T1, 10 E1, 11 idle |
| mode_chan | input | 7 | Channel used in unchannelized mode |
| out_vld | output | NUM_LINKS | Per-link tagged bit valid |
| out_bit | output | NUM_LINKS | Per-link forwarded bit |
| out_chan | output | 7*NUM_LINKS | Per-link channel, link i at bits [7i+6:7i] |

## Verification
Every result is due exactly one clock edge after the strobe that carries the bit. The bench drives inputs on the falling edge and compares `out_vld`, `out_bit` and `out_chan` on the next falling edge. A write takes effect at the edge it is sampled, but a link uses it only from its next frame-start bit. The bench's model therefore looks up the expected result with the pre-write tables and applies the write afterwards. Frame-start strobes, gaps in `rx_en` and mid-frame rewrites are generated per link, so each link's expected slot position follows only its own strobes.

// File: rtl/tsa_pkg.sv
// Shared types for the timeslot to channel assigner.
// Assumes a fixed 7-bit channel number and 32 timeslot positions per link.
package tsa_pkg;
    localparam int CHAN_W = 7;
    localparam int SLOT_N = 32;
    localparam int SLOT_W = $clog2(SLOT_N);
    localparam logic [SLOT_W-1:0] T1_LAST = SLOT_W'(24);
    localparam logic [SLOT_W-1:0] E1_LAST = SLOT_W'(31);

    typedef logic [CHAN_W-1:0] chan_t;

    typedef struct packed {
        logic  en;
        chan_t chan;
    } map_ent_t;

    typedef enum logic [1:0] {
        MODE_UNCH = 2'b00,
        MODE_T1   = 2'b01,
        MODE_E1   = 2'b10,
        MODE_IDLE = 2'b11
    } link_mode_e;
endpackage

// File: rtl/tsa_shadow_cfg.sv
// Shadow configuration store: per-link timeslot table plus link mode and
// unchannelized channel. Written by the two write ports at any time.
// Assumes the link fields select an existing link.
module tsa_shadow_cfg
    import tsa_pkg::*;
#(
    parameter int NUM_LINKS = 32,
    parameter int LINK_W    = 5
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               map_we,
    input  logic [LINK_W-1:0]                  map_link,
    input  logic [SLOT_W-1:0]                  map_slot,
    input  logic                               map_en,
    input  chan_t                              map_chan,
    input  logic                               mode_we,
    input  logic [LINK_W-1:0]                  mode_link,
    input  logic [1:0]                         mode_sel,
    input  chan_t                              mode_chan,
    output map_ent_t [NUM_LINKS-1:0][SLOT_N-1:0] sh_tab,
    output logic [NUM_LINKS-1:0][1:0]          sh_mode,
    output logic [NUM_LINKS-1:0][CHAN_W-1:0]   sh_chan
);
    // Table store: every entry disabled at reset, one entry per write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_tab <= '0;
        end else if (map_we) begin
            sh_tab[map_link][map_slot] <= '{en: map_en, chan: map_chan};
        end
    end

    // Link setting store: idle with channel 0 at reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int l = 0; l < NUM_LINKS; l++) begin
                sh_mode[l] <= MODE_IDLE;
                sh_chan[l] <= '0;
            end
        end else if (mode_we) begin
            sh_mode[mode_link] <= mode_sel;
            sh_chan[mode_link] <= mode_chan;
        end
    end
endmodule

// File: rtl/tsa_pos_cnt.sv
// Frame position counter for one link: timeslot number and bit within slot.
// Moves one bit per step. A step with fp marks the first bit of a frame.
// T1: slot 0 is the one-bit framing position, then slots 1..24 of 8 bits.
// E1: slots 0..31 of 8 bits each. Other modes: value unused.
module tsa_pos_cnt
    import tsa_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              fp,
    input  link_mode_e        mode,
    output logic [SLOT_W-1:0] slot,
    output logic [2:0]        bitn
);
    logic [SLOT_W-1:0] last_slot;

    // Last timeslot number of a frame for the current mode.
    always_comb last_slot = (mode == MODE_T1) ? T1_LAST : E1_LAST;

    // Advance to the position of the next bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot <= '0;
            bitn <= '0;
        end else if (step) begin
            if (fp) begin
                slot <= (mode == MODE_T1) ? SLOT_W'(1) : '0;
                bitn <= (mode == MODE_T1) ? 3'd0 : 3'd1;
            end else if (mode == MODE_T1 && slot == '0) begin
                slot <= SLOT_W'(1);
                bitn <= 3'd0;
            end else if (bitn == 3'd7) begin
                bitn <= 3'd0;
                slot <= (slot == last_slot) ? '0 : slot + SLOT_W'(1);
            end else begin
                bitn <= bitn + 3'd1;
            end
        end
    end
endmodule

// File: rtl/tsa_lane.sv
// One link lane: holds the active copy of its table row and settings and
// refreshes it on its frame-start bit. Tags each strobed bit with a channel,
// registered so the result appears one cycle after the strobe.
// Assumes rx_fp is only meaningful together with rx_en.
module tsa_lane
    import tsa_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rx_en,
    input  logic                   rx_bit,
    input  logic                   rx_fp,
    input  map_ent_t [SLOT_N-1:0]  sh_row,
    input  logic [1:0]             sh_mode,
    input  chan_t                  sh_chan,
    output logic                   out_vld,
    output logic                   out_bit,
    output chan_t                  out_chan
);
    map_ent_t [SLOT_N-1:0] act_row;
    link_mode_e            act_mode;
    chan_t                 act_chan;
    logic                  new_frame;
    link_mode_e            eff_mode;
    chan_t                 eff_chan;
    logic [SLOT_W-1:0]     slot_q;
    logic [2:0]            bit_q;
    logic [SLOT_W-1:0]     cur_slot;
    map_ent_t              ent;
    logic                  hit;
    chan_t                 hit_chan;

    // A frame starts only on a strobed bit that carries the frame pulse.
    always_comb new_frame = rx_en & rx_fp;

    // Active copy: loaded from the shadow at each frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_row  <= '0;
            act_mode <= MODE_IDLE;
            act_chan <= '0;
        end else if (new_frame) begin
            act_row  <= sh_row;
            act_mode <= link_mode_e'(sh_mode);
            act_chan <= sh_chan;
        end
    end

    // The frame-start bit itself already obeys the new settings.
    always_comb begin
        eff_mode = new_frame ? link_mode_e'(sh_mode) : act_mode;
        eff_chan = new_frame ? sh_chan : act_chan;
    end

    tsa_pos_cnt u_pos (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (rx_en),
        .fp    (rx_fp),
        .mode  (eff_mode),
        .slot  (slot_q),
        .bitn  (bit_q)
    );

    // Timeslot of the present bit; slot 0 on a frame start is never mapped.
    always_comb begin
        cur_slot = new_frame ? '0 : slot_q;
        ent      = act_row[cur_slot];
    end

    // Decide whether the present bit belongs to a channel, and which.
    always_comb begin
        hit      = 1'b0;
        hit_chan = ent.chan;
        unique case (eff_mode)
            MODE_UNCH: begin
                hit      = 1'b1;
                hit_chan = eff_chan;
            end
            MODE_T1, MODE_E1: hit = (cur_slot != '0) && ent.en;
            default:          hit = 1'b0;
        endcase
    end

    // Output register: one cycle from strobe to tagged bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld  <= 1'b0;
            out_bit  <= 1'b0;
            out_chan <= '0;
        end else begin
            out_vld  <= rx_en & hit;
            out_bit  <= rx_bit;
            out_chan <= hit_chan;
        end
    end
endmodule

// File: rtl/tsa_top.sv
// Timeslot to channel assigner top: one shadow store shared by all links
// and one lane per link. Links share the clock; each link advances on its
// own rx_en strobe, so each link is timed independently.
module tsa_top
    import tsa_pkg::*;
#(
    parameter int NUM_LINKS = 32,
    localparam int LINK_W   = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_LINKS-1:0]        rx_en,
    input  logic [NUM_LINKS-1:0]        rx_bit,
    input  logic [NUM_LINKS-1:0]        rx_fp,
    input  logic                        map_we,
    input  logic [LINK_W-1:0]           map_link,
    input  logic [4:0]                  map_slot,
    input  logic                        map_en,
    input  logic [6:0]                  map_chan,
    input  logic                        mode_we,
    input  logic [LINK_W-1:0]           mode_link,
    input  logic [1:0]                  mode_sel,
    input  logic [6:0]                  mode_chan,
    output logic [NUM_LINKS-1:0]        out_vld,
    output logic [NUM_LINKS-1:0]        out_bit,
    output logic [7*NUM_LINKS-1:0]      out_chan
);
    map_ent_t [NUM_LINKS-1:0][SLOT_N-1:0] sh_tab;
    logic [NUM_LINKS-1:0][1:0]            sh_mode;
    logic [NUM_LINKS-1:0][CHAN_W-1:0]     sh_chan;

    tsa_shadow_cfg #(
        .NUM_LINKS (NUM_LINKS),
        .LINK_W    (LINK_W)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .map_we    (map_we),
        .map_link  (map_link),
        .map_slot  (map_slot),
        .map_en    (map_en),
        .map_chan  (map_chan),
        .mode_we   (mode_we),
        .mode_link (mode_link),
        .mode_sel  (mode_sel),
        .mode_chan (mode_chan),
        .sh_tab    (sh_tab),
        .sh_mode   (sh_mode),
        .sh_chan   (sh_chan)
    );

    for (genvar i = 0; i < NUM_LINKS; i++) begin : g_lane
        tsa_lane u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .rx_en    (rx_en[i]),
            .rx_bit   (rx_bit[i]),
            .rx_fp    (rx_fp[i]),
            .sh_row   (sh_tab[i]),
            .sh_mode  (sh_mode[i]),
            .sh_chan  (sh_chan[i]),
            .out_vld  (out_vld[i]),
            .out_bit  (out_bit[i]),
            .out_chan (out_chan[CHAN_W*i +: CHAN_W])
        );
    end
endmodule

// File: rtl/tsa_chk.sv
// Property checker for tsa_top, bound into every instance of it.
// Relates strobes and pending link settings to the tagged output.
module tsa_chk #(
    parameter int NUM_LINKS = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NUM_LINKS-1:0]   rx_en,
    input logic [NUM_LINKS-1:0]   rx_bit,
    input logic [NUM_LINKS-1:0]   rx_fp,
    input logic [NUM_LINKS-1:0][1:0] sh_mode,
    input logic [NUM_LINKS-1:0][6:0] sh_chan,
    input logic [NUM_LINKS-1:0]   out_vld,
    input logic [NUM_LINKS-1:0]   out_bit,
    input logic [7*NUM_LINKS-1:0] out_chan
);
    for (genvar i = 0; i < NUM_LINKS; i++) begin : g_link
        // R3
        fp_bit_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rx_en[i] && rx_fp[i] && sh_mode[i] != 2'b00) |=> !out_vld[i]);
        // R2
        unch_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rx_en[i] && rx_fp[i] && sh_mode[i] == 2'b00)
            |=> (out_vld[i] && out_chan[7*i +: 7] == $past(sh_chan[i])));
        // R10
        no_strobe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !rx_en[i] |=> !out_vld[i]);
        // R2
        bit_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rx_en[i] |=> (out_bit[i] == $past(rx_bit[i])));
    end
endmodule

bind tsa_top tsa_chk #(.NUM_LINKS(NUM_LINKS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_en    (rx_en),
    .rx_bit   (rx_bit),
    .rx_fp    (rx_fp),
    .sh_mode  (sh_mode),
    .sh_chan  (sh_chan),
    .out_vld  (out_vld),
    .out_bit  (out_bit),
    .out_chan (out_chan)
);

// File: tb/tsa_top_tb.sv
// Bench for tsa_top with four links: writes a table from a vector array,
// then runs mixed-mode traffic with gaps and mid-frame rewrites against a
// model built from the requirements, then directed reset checks.
module tsa_top_tb;
    localparam int CLK_P = 10;
    localparam int NL    = 4;
    localparam int LW    = 2;
    localparam int NVEC  = 12;
    // {link[1:0], slot[4:0], en, chan[6:0]}, one pad bit on top
    localparam logic [15:0] VEC [NVEC] = '{
        {1'b0, 2'd1, 5'd1,  1'b1, 7'd5},   // R6 slot 1 -> 5
        {1'b0, 2'd1, 5'd2,  1'b1, 7'd5},   // R6 slot 2 -> 5
        {1'b0, 2'd1, 5'd7,  1'b1, 7'd5},   // R6 slot 7 -> 5, not adjacent
        {1'b0, 2'd1, 5'd3,  1'b1, 7'd20},
        {1'b0, 2'd1, 5'd31, 1'b1, 7'd127},
        {1'b0, 2'd1, 5'd0,  1'b1, 7'd1},   // R4 E1 slot 0 enabled yet dropped
        {1'b0, 2'd1, 5'd16, 1'b0, 7'd3},   // R5 disabled entry
        {1'b0, 2'd2, 5'd1,  1'b1, 7'd0},
        {1'b0, 2'd2, 5'd24, 1'b1, 7'd66},
        {1'b0, 2'd2, 5'd12, 1'b1, 7'd5},
        {1'b0, 2'd2, 5'd0,  1'b1, 7'd8},   // R3 framing position never passed
        {1'b0, 2'd2, 5'd13, 1'b1, 7'd12}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NL-1:0] rx_en = '0, rx_bit = '0, rx_fp = '0;
    logic map_we = 1'b0, map_en = 1'b0, mode_we = 1'b0;
    logic [LW-1:0] map_link = '0, mode_link = '0;
    logic [4:0] map_slot = '0;
    logic [6:0] map_chan = '0, mode_chan = '0;
    logic [1:0] mode_sel = '0;
    logic [NL-1:0] out_vld, out_bit;
    logic [7*NL-1:0] out_chan;

    int checks = 0;
    int errors = 0;

    // Model state
    logic [7:0] m_sh [NL][32];
    logic [7:0] m_act [NL][32];
    logic [1:0] m_shm [NL], m_actm [NL];
    logic [6:0] m_shc [NL], m_actc [NL];
    int m_slot [NL], m_bit [NL];
    logic e_vld [NL], e_bit [NL];
    logic [6:0] e_chan [NL];
    string e_tag [NL];
    int fcnt [NL], fper [NL];
    logic [15:0] lfsr = 16'hACE1;

    always #(CLK_P/2) clk = ~clk;

    tsa_top #(.NUM_LINKS(NL)) u_dut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_bit(rx_bit), .rx_fp(rx_fp),
        .map_we(map_we), .map_link(map_link), .map_slot(map_slot),
        .map_en(map_en), .map_chan(map_chan), .mode_we(mode_we),
        .mode_link(mode_link), .mode_sel(mode_sel), .mode_chan(mode_chan),
        .out_vld(out_vld), .out_bit(out_bit), .out_chan(out_chan)
    );

    task automatic chk(input logic ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int period_of(input logic [1:0] m);
        case (m)
            2'b00:   return 100;
            2'b01:   return 193;
            2'b10:   return 256;
            default: return 64;
        endcase
    endfunction

    task automatic model_reset();
        for (int l = 0; l < NL; l++) begin
            for (int s = 0; s < 32; s++) begin
                m_sh[l][s] = '0;
                m_act[l][s] = '0;
            end
            m_shm[l] = 2'b11; m_actm[l] = 2'b11;
            m_shc[l] = '0;    m_actc[l] = '0;
            m_slot[l] = 0;    m_bit[l] = 0;
            fcnt[l] = 0;      fper[l] = 64;
        end
    endtask

    // One clock: model the edge, then compare at the following falling edge.
    task automatic tick();
        @(posedge clk);
        for (int l = 0; l < NL; l++) begin
            e_vld[l] = 1'b0; e_bit[l] = rx_bit[l]; e_chan[l] = '0;
            e_tag[l] = "R10";
            if (rx_en[l]) begin
                int cs;
                logic [1:0] em;
                logic [7:0] ent;
                if (rx_fp[l]) begin
                    for (int s = 0; s < 32; s++) m_act[l][s] = m_sh[l][s];
                    m_actm[l] = m_shm[l];
                    m_actc[l] = m_shc[l];
                end
                em = m_actm[l];
                cs = rx_fp[l] ? 0 : m_slot[l];
                ent = m_act[l][cs];
                case (em)
                    2'b00: begin e_vld[l] = 1'b1; e_chan[l] = m_actc[l]; e_tag[l] = "R2"; end
                    2'b01, 2'b10: begin
                        e_vld[l] = (cs != 0) && ent[7];
                        e_chan[l] = ent[6:0];
                        e_tag[l] = (cs == 0) ? ((em == 2'b01) ? "R3" : "R4")
                                 : (ent[7] ? "R6 R8" : "R5");
                    end
                    default: e_tag[l] = "R9 R7";
                endcase
                if (rx_fp[l]) begin
                    m_slot[l] = (em == 2'b01) ? 1 : 0;
                    m_bit[l]  = (em == 2'b01) ? 0 : 1;
                end else if (em == 2'b01 && m_slot[l] == 0) begin
                    m_slot[l] = 1; m_bit[l] = 0;
                end else if (m_bit[l] == 7) begin
                    m_bit[l] = 0;
                    m_slot[l] = (m_slot[l] == ((em == 2'b01) ? 24 : 31)) ? 0 : m_slot[l] + 1;
                end else begin
                    m_bit[l]++;
                end
            end
        end
        if (map_we) m_sh[map_link][map_slot] = {map_en, map_chan};
        if (mode_we) begin
            m_shm[mode_link] = mode_sel;
            m_shc[mode_link] = mode_chan;
        end
        @(negedge clk);
        for (int l = 0; l < NL; l++) begin
            chk(out_vld[l] == e_vld[l], e_tag[l], "out_vld", out_vld[l], e_vld[l]);
            if (e_vld[l]) begin
                chk(out_bit[l] == e_bit[l], e_tag[l], "out_bit", out_bit[l], e_bit[l]);
                chk(out_chan[7*l +: 7] == e_chan[l], e_tag[l], "out_chan",
                    out_chan[7*l +: 7], e_chan[l]);
            end
        end
        map_we = 1'b0;
        mode_we = 1'b0;
    endtask

    task automatic wr_map(input logic [1:0] l, input logic [4:0] s,
                          input logic en, input logic [6:0] c);
        map_we = 1'b1; map_link = l; map_slot = s; map_en = en; map_chan = c;
    endtask

    task automatic wr_mode(input logic [1:0] l, input logic [1:0] m,
                           input logic [6:0] c);
        mode_we = 1'b1; mode_link = l; mode_sel = m; mode_chan = c;
    endtask

    // Drive one cycle of traffic: gapped strobes, per-link frame pulses.
    task automatic traffic(input int gap_on);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        for (int l = 0; l < NL; l++) begin
            rx_en[l]  = gap_on ? (lfsr[l] | lfsr[l+4]) : 1'b1;
            rx_bit[l] = lfsr[l+8];
            rx_fp[l]  = rx_en[l] && (fcnt[l] == 0);
            if (rx_fp[l]) fper[l] = period_of(m_shm[l]);
            if (rx_en[l]) fcnt[l] = (fcnt[l] + 1) % fper[l];
        end
        tick();
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        model_reset();
        @(negedge clk);
        rx_en = '1; rx_fp = '1;
        // R1: nothing valid while reset is held
        tick(); tick();
        rst_n = 1'b1;
        rx_fp = '0;
        // R1: after release, idle links stay silent even with frame pulses
        rx_fp = '1; tick(); rx_fp = '0; tick();
        rx_en = '0;
        model_reset();
        for (int l = 0; l < NL; l++) fcnt[l] = 0;

        // Table writes from the vector array
        for (int v = 0; v < NVEC; v++) begin
            wr_map(VEC[v][14:13], VEC[v][12:8], VEC[v][7], VEC[v][6:0]);
            tick();
        end
        wr_mode(2'd0, 2'b00, 7'd9);  tick();
        wr_mode(2'd1, 2'b10, 7'd0);  tick();
        wr_mode(2'd2, 2'b01, 7'd0);  tick();
        wr_mode(2'd3, 2'b11, 7'd4);  tick();

        // R7: strobes without a frame pulse keep the old (idle) settings
        for (int c = 0; c < 20; c++) begin
            rx_en = '1; rx_fp = '0; rx_bit = c[3:0]; tick();
        end
        rx_en = '0;
        for (int l = 0; l < NL; l++) fcnt[l] = 0;

        // R8: mixed-mode run, first without gaps, then with gaps (R10)
        for (int c = 0; c < 600; c++) traffic(0);
        for (int c = 0; c < 3000; c++) begin
            if (c == 700) begin wr_map(2'd1, 5'd3, 1'b0, 7'd20); end      // R7 mid-frame
            if (c == 701) begin wr_map(2'd1, 5'd4, 1'b1, 7'd77); end
            if (c == 1500) begin wr_mode(2'd2, 2'b10, 7'd0); end          // T1 -> E1
            if (c == 1501) begin wr_mode(2'd3, 2'b00, 7'd42); end         // idle -> unch
            if (c == 2200) begin wr_mode(2'd0, 2'b11, 7'd0); end          // R9
            if (c == 2201) begin wr_map(2'd2, 5'd0, 1'b1, 7'd99); end     // R4
            traffic(1);
        end

        // R10: frame pulse without strobe is ignored
        rx_en = '0; rx_fp = '1; tick(); tick();
        rx_fp = '0;

        // R1: reset in mid-traffic clears outputs and settings
        rx_en = '1;
        rst_n = 1'b0;
        model_reset();
        tick();
        rst_n = 1'b1;
        rx_fp = '1; tick();
        rx_fp = '0; tick(); tick();
        rx_en = '0; tick();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule